// File: doc/BRIEF.md
# Infrared-Ready Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial frames on a single output pin. Each frame has one low start bit, eight data bits sent least significant bit first and one high stop bit. Every bit lasts a programmable number of clock cycles. A byte is handed over with a valid/ready handshake, and a busy flag shows when a frame is pending or on the wire.

For infrared links, the pin can carry a square-wave carrier instead of a plain low level. An 8-bit reload timer makes the carrier. With modulation on, the pin toggles at the carrier rate while the serial level is low. While the serial level is high, the pin holds a level chosen by a control bit. Idle time and stop bits are high, so the carrier only appears while data is going out. This suits LED drivers that light on either polarity.

Top module: `ir_uart_tx`

## Requirements
- R1: After reset, `tx_out` is 1, `tx_ready` is 1 and `tx_busy` is 0.
- R2: A frame is a start bit at level 0, then the eight bits of the byte least significant bit first, then a stop bit at level 1. Each bit lasts `baud_div` clock cycles (`baud_div` >= 2).
- R3: With `mod_en` = 0, `tx_out` follows the serial level, one clock after it.
- R4: With `mod_en` = 1, `tx_out` toggles every 256 - `carrier_reload` clock cycles while the serial level is 0.
- R5: With `mod_en` = 1 and the serial level at 1, `tx_out` is held constant at `mark_high` (0 = held low, 1 = held high).
- R6: With `mod_en` = 1 and no frame in progress, `tx_out` shows no carrier and rests at `mark_high`.
- R7: The carrier timer runs freely. It counts up from `carrier_reload` to 0xFF, reloads on overflow and toggles the carrier on each overflow. It is never restarted at bit or frame boundaries.
- R8: A change of `mod_en` or `mark_high` takes effect at the pin one clock later, even in the middle of a frame.
- R9: `tx_ready` is 1 only while no frame is pending or in progress, and `tx_busy` is its inverse. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. A `tx_valid` while busy is ignored and starts no frame.
- R10: The start bit begins at the first bit tick after acceptance. It therefore reaches `tx_out` within `baud_div` + 1 cycles of the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| baud_div | input | DIV_W | Clock cycles per bit |
| carrier_reload | input | 8 | Carrier timer start value |
| mod_en | input | 1 | Enables carrier modulation |
| mark_high | input | 1 | Pin level during high serial bits when modulating |
| tx_out | output | 1 | Serial / infrared drive pin |
| tx_busy | output | 1 | Frame pending or being sent |

## Verification
The pin is registered, so each serial level, carrier edge or control change reaches `tx_out` one cycle after the internal state changes. The start bit appears within `baud_div` + 1 cycles of acceptance. The bench first waits for the start bit's falling edge. It then samples each bit half a bit time later, and after that every `baud_div` cycles, always on the falling clock edge. Carrier checks do not depend on phase, because the carrier runs freely: they count toggles and measure the gaps between toggles over windows whose lengths follow from `baud_div` and `carrier_reload`. After each control change they allow two cycles before checking.

// File: rtl/ir_uart_tx.sv
module ir_uart_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [7:0]       carrier_reload,
  input  logic             mod_en,
  input  logic             mark_high,
  output logic             tx_out,
  output logic             tx_busy
);
  localparam int FRAME_BITS = 10;
  localparam int LEFT_W     = $clog2(FRAME_BITS + 1);

  logic [DIV_W-1:0]      bcnt;
  logic [DIV_W-1:0]      div_m1;
  logic                  tick;
  logic                  pend;
  logic [LEFT_W-1:0]     left;
  logic [FRAME_BITS-1:0] sh;
  logic                  ser;
  logic [7:0]            tmr;
  logic                  car;
  logic                  tx_q;

  assign div_m1   = (baud_div == '0) ? '0 : baud_div - 1'b1;
  assign tick     = (bcnt >= div_m1);
  assign tx_busy  = pend | (left != '0);
  assign tx_ready = ~tx_busy;
  assign ser      = (left != '0) ? sh[0] : 1'b1;
  assign tx_out   = tx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? '0 : bcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= 1'b0;
      left <= '0;
      sh   <= '1;
    end else if (tx_valid && tx_ready) begin
      pend <= 1'b1;
      sh   <= {1'b1, tx_data, 1'b0};
    end else if (tick) begin
      if (pend) begin
        pend <= 1'b0;
        left <= LEFT_W'(FRAME_BITS);
      end else if (left != '0) begin
        left <= left - 1'b1;
        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr <= '0;
      car <= 1'b0;
    end else if (tmr == 8'hFF) begin
      tmr <= carrier_reload;
      car <= ~car;
    end else begin
      tmr <= tmr + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_q <= 1'b1;
    else        tx_q <= mod_en ? (ser ? mark_high : car) : ser;

  a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> tx_busy);

  a_r9_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ready);

  a_r3_plain_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en && !tx_busy) |=> tx_out);

  a_r6_mod_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tx_busy) |=> (tx_out == $past(mark_high)));

  a_r7_carrier_only_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr != 8'hFF) |=> $stable(car));

  a_r2_frame_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pend && !(tx_valid && tx_ready)) |=> $stable(left));
endmodule

// File: tb/ir_uart_tx_tb_top.sv
module ir_uart_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] baud_div = 16'd16;
  logic [7:0]  carrier_reload = 8'hFC;
  logic        mod_en = 1'b0;
  logic        mark_high = 1'b0;
  logic        tx_out;
  logic        tx_busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ir_uart_tx #(.DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .baud_div(baud_div), .carrier_reload(carrier_reload),
    .mod_en(mod_en), .mark_high(mark_high), .tx_out(tx_out), .tx_busy(tx_busy)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic send(input logic [7:0] b);
    int n = 0;
    @(negedge clk);
    while (!tx_ready && n < 2000) begin @(negedge clk); n++; end
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!tx_ready && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic decode(input logic [7:0] exp);
    int lat = 1;
    int d = int'(baud_div);
    logic [7:0] got;
    while (tx_out && lat < 4 * d) begin @(negedge clk); lat++; end
    chk_range("R10 start latency", lat, 1, d + 1);
    repeat (d / 2) @(negedge clk);
    chk("R2 start bit level", int'(tx_out), 0);
    chk("R9 busy in frame", int'({tx_busy, tx_ready}), 2);
    for (int i = 0; i < 8; i++) begin
      repeat (d) @(negedge clk);
      got[i] = tx_out;
    end
    chk("R2 R3 data bits", int'(got), int'(exp));
    repeat (d) @(negedge clk);
    chk("R2 stop bit level", int'(tx_out), 1);
    wait_ready();
    chk("R9 ready after frame", int'(tx_ready), 1);
  endtask

  task automatic t_reset();
    chk("R1 reset tx_out", int'(tx_out), 1);
    chk("R1 reset ready", int'(tx_ready), 1);
    chk("R1 reset busy", int'(tx_busy), 0);
  endtask

  task automatic t_plain(input logic [15:0] div, input logic [7:0] b);
    baud_div = div; mod_en = 1'b0;
    send(b);
    decode(b);
  endtask

  task automatic t_busy_ignored();
    int moved = 0;
    baud_div = 16'd16; mod_en = 1'b0;
    send(8'h81);
    tx_data = 8'h00; tx_valid = 1'b1;
    repeat (2) @(negedge clk);
    tx_valid = 1'b0;
    decode(8'h81);
    repeat (48) begin
      @(negedge clk);
      if (!tx_out || !tx_ready) moved++;
    end
    chk("R9 write while busy ignored", moved, 0);
  endtask

  task automatic count_toggles(input int n, output int tog, output int gap_ok, input int half);
    logic prev = tx_out;
    int gap = 0;
    tog = 0; gap_ok = 0;
    repeat (n) begin
      @(negedge clk);
      gap++;
      if (tx_out != prev) begin
        if (gap == half) gap_ok++;
        tog++; gap = 0;
      end
      prev = tx_out;
    end
  endtask

  task automatic t_mod_idle();
    int tog, ok, bad;
    baud_div = 16'd32; carrier_reload = 8'hFC; mod_en = 1'b1; mark_high = 1'b0;
    repeat (2) @(negedge clk);
    count_toggles(40, tog, ok, 4);
    chk("R6 no carrier when idle", tog, 0);
    chk("R6 idle rests at mark_high=0", int'(tx_out), 0);
    mark_high = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 R8 idle follows mark_high=1", int'(tx_out), 1);
    bad = 0;
    repeat (40) begin @(negedge clk); if (!tx_out) bad++; end
    chk("R6 held high when idle", bad, 0);
  endtask

  task automatic t_mod_zero();
    int tog, ok;
    baud_div = 16'd32; carrier_reload = 8'hFC; mod_en = 1'b1; mark_high = 1'b0;
    @(negedge clk);
    send(8'h00);
    count_toggles(360, tog, ok, 4);
    chk_range("R4 carrier toggles over 9 low bits", tog, 66, 76);
    chk_range("R4 R7 half period 256-reload", ok, 60, 76);
    chk("R5 stop bit held low", int'(tx_out), 0);
    wait_ready();
  endtask

  task automatic t_mod_ones();
    int tog, ok, bad = 0;
    baud_div = 16'd32; carrier_reload = 8'hFC; mod_en = 1'b1; mark_high = 1'b1;
    @(negedge clk);
    send(8'hFF);
    count_toggles(80, tog, ok, 4);
    chk_range("R4 carrier only in start bit", tog, 6, 10);
    repeat (260) begin @(negedge clk); if (!tx_out) bad++; end
    chk("R5 high bits held at mark_high=1", bad, 0);
    wait_ready();
  endtask

  task automatic t_slow_carrier();
    int tog, ok;
    baud_div = 16'd64; carrier_reload = 8'hF0; mod_en = 1'b1; mark_high = 1'b0;
    @(negedge clk);
    send(8'h00);
    count_toggles(700, tog, ok, 16);
    chk_range("R7 reload 0xF0 gives 16-cycle half period", ok, 30, 40);
    wait_ready();
  endtask

  task automatic t_midframe_switch();
    int tog, ok, n = 0;
    baud_div = 16'd32; carrier_reload = 8'hFC; mod_en = 1'b0; mark_high = 1'b0;
    @(negedge clk);
    send(8'h00);
    while (tx_out && n < 200) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    mod_en = 1'b1;
    count_toggles(40, tog, ok, 4);
    chk_range("R8 carrier starts mid-frame", tog, 8, 11);
    mod_en = 1'b0;
    repeat (2) @(negedge clk);
    count_toggles(30, tog, ok, 4);
    chk("R3 R8 plain again mid-frame", tog, 0);
    chk("R3 plain low data level", int'(tx_out), 0);
    wait_ready();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_plain(16'd16, 8'hA5);
    t_plain(16'd8, 8'h3C);
    t_plain(16'd4, 8'h01);
    t_busy_ignored();
    t_mod_idle();
    t_mod_zero();
    t_mod_ones();
    t_slow_carrier();
    t_midframe_switch();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule